// File: doc/BRIEF.md
# Deskew Channel Frame Generator

This block sits on the transmit side of a multi-lane serial link and builds the extra deskew lane that a receiver uses to line up the data lanes. Each bit time it takes one parallel sample of all data lanes. It copies the sample of one lane, chosen by a rotating pointer, onto a single serial output. Every four copied samples it appends a parity bit. These five-bit elements form a repeating reference frame. The number of lanes is fixed when the block is built. That lane count sets how many elements a frame holds and which of them carry even or odd parity.

The lane pointer starts on the highest lane and steps down by one for each data bit. After the lowest lane it wraps to the highest lane, and it stays where it is during parity bits. At the end of every frame the pointer returns to the highest lane. An option inverts the data bits of the odd-parity elements, which raises the transition density of the lane. That option is latched once per frame. When the enable input is low, the generator stops in place.

Top module: `dskw_gen`

## Requirements
- R1: A synchronous reset drives `dsk_o` to 0. The first enabled bit after reset is bit 0 of a frame and carries the sample of lane N_LANES-1.
- R2: Within a frame, data bit j (counting only data bits, from 0) carries lane N_LANES-1-(j mod N_LANES). A frame position p is a data bit when p mod 5 is 0 to 3, and its element index is p/5, so j = 4*(p/5) + (p mod 5). The lane pointer does not move during parity bits.
- R3: Every frame restarts on lane N_LANES-1, whatever lane the previous frame ended on.
- R4: A frame has E elements of 5 bits each, so it is 5*E bits long. E is 2 for 4 to 8 lanes, 3 for 9 to 12, 4 for 13 to 16 and 5 for 17 to 20. Listed by element index from 0, the parity kinds are: even,odd; even,even,odd; even,even,odd,odd; even,even,odd,even,odd.
- R5: Bit 4 of an element is its parity bit. In an even element it makes the XOR of the five transmitted bits 0. In an odd element it makes that XOR 1.
- R6: When inversion is active for a frame, the data bits of odd elements are sent inverted. Even elements are not affected. R5 still holds on the transmitted bits.
- R7: `inv_odd_i` is sampled only on frame bit 0. Changes at other bit positions take effect from the next frame.
- R8: While `en_i` is low, `dsk_o` and the frame position hold their values.
- R9: With inversion active, no run of identical bits on `dsk_o` exceeds 18 enabled bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-time clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance one bit time when high |
| inv_odd_i | input | 1 | Invert data bits of odd elements, sampled at frame start |
| lane_data_i | input | N_LANES | Current sample of each data lane |
| dsk_o | output | 1 | Registered deskew lane bit |

## Verification
Two events can fall in the same cycle. The lane pointer wrapping from lane 0 back to the top can coincide with the frame restart. Separately, sampling the inversion option can coincide with a toggle of `inv_odd_i`. The 12-lane instance forces the first case: its twelve data bits per frame end on lane 0 exactly at frame end. The 17-lane instance wraps in the middle of a frame instead. During stretches where `inv_odd_i` toggles every cycle and enable drops at random, each output bit is compared with a model. The model derives the lane index, the element kind and the latched inversion purely from the count of enabled bits since reset.

// File: rtl/dskw_pkg.sv
package dskw_pkg;

   localparam int ELEM_BITS = 5;
   localparam int DATA_BITS = 4;

   // number of parity elements per reference frame for a lane count
   function automatic int elem_count(input int lanes);
      if (lanes <= 8)       return 2;
      else if (lanes <= 12) return 3;
      else if (lanes <= 16) return 4;
      else                  return 5;
   endfunction

   // bit e set means element e is an odd parity element
   function automatic logic [7:0] odd_pattern(input int lanes);
      case (elem_count(lanes))
         2:       return 8'b0000_0010;
         3:       return 8'b0000_0100;
         4:       return 8'b0000_1100;
         default: return 8'b0001_0100;
      endcase
   endfunction

endpackage

// File: rtl/dskw_seq.sv
module dskw_seq #(
   parameter int N_ELEM = 2,
   localparam int EW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          en_i,
   output logic [2:0]    slot_o,
   output logic [EW-1:0] elem_o,
   output logic          data_slot_o,
   output logic          par_slot_o,
   output logic          frame_first_o,
   output logic          frame_last_o
);
   import dskw_pkg::*;

   localparam logic [EW-1:0] LAST_E   = EW'(N_ELEM - 1);
   localparam logic [2:0]    PAR_SLOT = 3'(DATA_BITS);

   if (N_ELEM < 2 || N_ELEM > 5) begin : g_bad_elem
      $error("dskw_seq: N_ELEM out of range");
   end

   logic [2:0]    slot_q;
   logic [EW-1:0] elem_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         slot_q <= '0;
         elem_q <= '0;
      end else if (en_i) begin
         if (slot_q == PAR_SLOT) begin
            slot_q <= '0;
            elem_q <= (elem_q == LAST_E) ? '0 : elem_q + EW'(1);
         end else begin
            slot_q <= slot_q + 3'd1;
         end
      end
   end

   always_comb begin
      slot_o        = slot_q;
      elem_o        = elem_q;
      par_slot_o    = (slot_q == PAR_SLOT);
      data_slot_o   = !par_slot_o;
      frame_first_o = (slot_q == 3'd0) && (elem_q == '0);
      frame_last_o  = par_slot_o && (elem_q == LAST_E);
   end

   p_slot_bound_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (slot_q <= PAR_SLOT) && (elem_q <= LAST_E));

endmodule

// File: rtl/dskw_lane_sel.sv
module dskw_lane_sel #(
   parameter int N_LANES = 4,
   localparam int LW = $clog2(N_LANES)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   input  logic               adv_i,
   input  logic               restart_i,
   input  logic [N_LANES-1:0] lane_data_i,
   output logic               lane_bit_o
);
   localparam logic [LW-1:0] TOP = LW'(N_LANES - 1);

   logic [LW-1:0]      ptr_q;
   logic [N_LANES-1:0] sel;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ptr_q <= TOP;
      end else if (en_i) begin
         if (restart_i)
            ptr_q <= TOP;
         else if (adv_i)
            ptr_q <= (ptr_q == '0) ? TOP : ptr_q - LW'(1);
      end
   end

   for (genvar g = 0; g < N_LANES; g++) begin : g_sel
      assign sel[g] = (ptr_q == LW'(g));
   end

   assign lane_bit_o = |(lane_data_i & sel);

   p_ptr_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot(sel));

   p_ptr_hold_parity_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !adv_i && !restart_i) |=> $stable(ptr_q));

   p_restart_top_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && restart_i) |=> (ptr_q == TOP));

endmodule

// File: rtl/dskw_parity.sv
module dskw_parity (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic data_slot_i,
   input  logic elem_first_i,
   input  logic odd_elem_i,
   input  logic frame_first_i,
   input  logic inv_odd_i,
   input  logic lane_bit_i,
   output logic dsk_o
);
   logic inv_q;
   logic acc_q;
   logic txx_q;
   logic dsk_q;
   logic inv_eff;
   logic tx_bit;

   always_comb begin
      inv_eff = frame_first_i ? inv_odd_i : inv_q;
      tx_bit  = lane_bit_i ^ (inv_eff & odd_elem_i);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         inv_q <= 1'b0;
         acc_q <= 1'b0;
         txx_q <= 1'b0;
         dsk_q <= 1'b0;
      end else if (en_i) begin
         if (frame_first_i)
            inv_q <= inv_odd_i;
         if (data_slot_i) begin
            dsk_q <= tx_bit;
            acc_q <= elem_first_i ? lane_bit_i : (acc_q ^ lane_bit_i);
            txx_q <= elem_first_i ? tx_bit : (txx_q ^ tx_bit);
         end else begin
            dsk_q <= acc_q ^ odd_elem_i;
         end
      end
   end

   assign dsk_o = dsk_q;

   p_elem_parity_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !data_slot_i) |=> ((txx_q ^ dsk_q) == $past(odd_elem_i)));

   p_even_plain_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && data_slot_i && !odd_elem_i) |=> (dsk_q == $past(lane_bit_i)));

   p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(dsk_q));

endmodule

// File: rtl/dskw_gen.sv
module dskw_gen #(
   parameter int N_LANES = 4
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   input  logic               inv_odd_i,
   input  logic [N_LANES-1:0] lane_data_i,
   output logic               dsk_o
);
   import dskw_pkg::*;

   localparam int         N_ELEM  = elem_count(N_LANES);
   localparam int         EW      = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;
   localparam logic [7:0] ODD_PAT = odd_pattern(N_LANES);

   if (N_LANES < 4 || N_LANES > 20) begin : g_bad_lanes
      $error("dskw_gen: N_LANES must lie in 4..20");
   end

   logic [2:0]    slot;
   logic [EW-1:0] elem;
   logic          data_slot;
   logic          par_slot;
   logic          frame_first;
   logic          frame_last;
   logic          lane_bit;
   logic          odd_elem;

   dskw_seq #(.N_ELEM(N_ELEM)) u_seq (
      .clk_i         (clk_i),
      .rst_i         (rst_i),
      .en_i          (en_i),
      .slot_o        (slot),
      .elem_o        (elem),
      .data_slot_o   (data_slot),
      .par_slot_o    (par_slot),
      .frame_first_o (frame_first),
      .frame_last_o  (frame_last)
   );

   dskw_lane_sel #(.N_LANES(N_LANES)) u_lane (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .en_i        (en_i),
      .adv_i       (data_slot),
      .restart_i   (frame_last),
      .lane_data_i (lane_data_i),
      .lane_bit_o  (lane_bit)
   );

   assign odd_elem = ODD_PAT[elem];

   dskw_parity u_par (
      .clk_i         (clk_i),
      .rst_i         (rst_i),
      .en_i          (en_i),
      .data_slot_i   (data_slot),
      .elem_first_i  (slot == 3'd0),
      .odd_elem_i    (odd_elem),
      .frame_first_i (frame_first),
      .inv_odd_i     (inv_odd_i),
      .lane_bit_i    (lane_bit),
      .dsk_o         (dsk_o)
   );

   p_first_even_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_first |-> !odd_elem);

   p_last_odd_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && frame_last) |-> (odd_elem && par_slot));

endmodule

// File: tb/dskw_gen_bench.sv
module dskw_gen_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic        inv = 1'b0;
   logic [16:0] data = '0;
   logic        dsk17, dsk12;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   dskw_gen #(.N_LANES(17)) u_dskw_gen (
      .clk_i(clk), .rst_i(rst), .en_i(en), .inv_odd_i(inv),
      .lane_data_i(data), .dsk_o(dsk17));

   dskw_gen #(.N_LANES(12)) u_dskw_gen_n12 (
      .clk_i(clk), .rst_i(rst), .en_i(en), .inv_odd_i(inv),
      .lane_data_i(data[11:0]), .dsk_o(dsk12));

   // model state per instance: 0 -> 17 lanes, 1 -> 12 lanes
   int  pos[2];
   bit  accm[2];
   bit  invf[2];
   bit  expo[2];
   bit  fresh[2];
   bit  track_runs = 0;
   int  run_len[2];
   int  max_run[2];
   bit  last_bit[2];
   logic [31:0] lfsr = 32'h1234_5678;

   function automatic int lanes_of(int i);
      return (i == 0) ? 17 : 12;
   endfunction

   function automatic int ecount(int n);
      if (n <= 8)  return 2;
      if (n <= 12) return 3;
      if (n <= 16) return 4;
      return 5;
   endfunction

   function automatic bit odd_of(int n, int e);
      case (ecount(n))
         2: return e == 1;
         3: return e == 2;
         4: return e >= 2;
         default: return (e == 2) || (e == 4);
      endcase
   endfunction

   function automatic logic [31:0] next_rand(logic [31:0] x);
      logic [31:0] y = x;
      y = y ^ (y << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic chk(input bit act, input bit exp, input string tag, input int i);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s lanes=%0d pos=%0d: actual %0b expected %0b",
                  tag, lanes_of(i), pos[i], act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      en  = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 2; i++) begin
         pos[i] = 0; accm[i] = 0; expo[i] = 0; fresh[i] = 1;
         run_len[i] = 0; max_run[i] = 0; last_bit[i] = 0;
      end
      chk(dsk17, 1'b0, "R1 reset", 0);
      chk(dsk12, 1'b0, "R1 reset", 1);
   endtask

   task automatic tick(input bit e, input bit iv, input logic [16:0] d);
      bit    act;
      string tag;
      @(negedge clk);
      en = e; inv = iv; data = d;
      @(posedge clk);
      #1;
      for (int i = 0; i < 2; i++) begin
         int n = lanes_of(i);
         act = (i == 0) ? dsk17 : dsk12;
         if (!e) begin
            chk(act, expo[i], "R8 hold", i);
         end else begin
            int el, sl, lane;
            bit od, raw;
            if (pos[i] == 0) invf[i] = iv;
            el = pos[i] / 5;
            sl = pos[i] % 5;
            od = odd_of(n, el);
            if (sl < 4) begin
               lane = n - 1 - ((el * 4 + sl) % n);
               raw  = d[lane];
               accm[i] = (sl == 0) ? raw : (accm[i] ^ raw);
               expo[i] = raw ^ (invf[i] & od);
               if (fresh[i])                  tag = "R1 first bit";
               else if (pos[i] == 0)          tag = "R3 frame restart";
               else if (od && invf[i] != iv)  tag = "R7 latched inversion";
               else if (od && invf[i])        tag = "R6 inverted data";
               else                           tag = "R2 lane order";
            end else begin
               expo[i] = accm[i] ^ od;
               tag = "R4 R5 parity";
            end
            chk(act, expo[i], tag, i);
            fresh[i] = 0;
            pos[i] = (pos[i] + 1) % (5 * ecount(n));
            if (track_runs) begin
               if (act == last_bit[i]) run_len[i]++;
               else run_len[i] = 1;
               last_bit[i] = act;
               if (run_len[i] > max_run[i]) max_run[i] = run_len[i];
            end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      do_reset();

      // plain frames, random data, inversion off
      for (int k = 0; k < 300; k++) begin
         lfsr = next_rand(lfsr);
         tick(1'b1, 1'b0, lfsr[16:0]);
      end

      // enable gaps and inversion toggling at arbitrary positions
      for (int k = 0; k < 800; k++) begin
         lfsr = next_rand(lfsr);
         tick(lfsr[20:19] != 2'b00, lfsr[23], lfsr[16:0]);
      end

      // reset mid-run, then inversion held on for run-length checks
      @(negedge clk);
      inv = 1'b1;
      do_reset();
      track_runs = 1;
      for (int k = 0; k < 150; k++) tick(1'b1, 1'b1, 17'h00000);
      for (int k = 0; k < 150; k++) tick(1'b1, 1'b1, 17'h1FFFF);
      for (int k = 0; k < 150; k++) tick(1'b1, 1'b1, (k % 2) ? 17'h15555 : 17'h0AAAA);
      for (int k = 0; k < 900; k++) begin
         lfsr = next_rand(lfsr);
         tick(1'b1, 1'b1, lfsr[16:0] & {17{lfsr[29]}});
      end
      for (int i = 0; i < 2; i++) begin
         checks++;
         if (max_run[i] > 18) begin
            fails++;
            $display("FAIL R9 lanes=%0d: actual run %0d expected at most 18",
                     lanes_of(i), max_run[i]);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule